// File: doc/BRIEF.md
# Key-Guarded Sequence Table

This block stores the instruction table that a serial-memory sequencer runs from: 64 words of 32 bits, grouped as 16 sequences of four consecutive words. Software reaches it through a simple 32-bit register bus. The sequencer has its own read port, which runs at the same time as bus accesses. Which instructions the words encode, and how they drive the serial lines, lies outside this block.

A lock guards the table. While it is closed, bus writes to table words are dropped without any error. The lock changes state only through a lock-control write that comes directly after a write of the 32-bit key to the key register. Any other bus write in between disarms the key.

Software therefore updates the table in this order: key, unlock, table words, key, lock. Sequence 0 leaves reset holding a basic single-lane read sequence, so memory reads work before any programming. The block leaves reset locked.

Top module: `lutk_table`

## Requirements
- R1: After reset `locked` is 1, and a bus read of the lock-control register at byte offset 0x304 returns 0x00000001.
- R2: After reset, word 0 holds 0x08180403 and word 1 holds 0x00001C04. Each 16-bit slot is {opcode[5:0], lane code[1:0], operand[7:0]}: command 0x03, then a 24-bit address, then a read, then stop. Every other word resets to 0.
- R3: A bus write of 0x5AF05AF0 to the key register at byte offset 0x300 arms the lock. A lock-control write is honoured only while armed. Cycles with no bus write do not disarm.
- R4: Any bus write other than the correct key to the key register disarms. This includes a wrong key value, a table write and a lock-control write.
- R5: An armed lock-control write with data bits [1:0] = 2'b01 locks and 2'b10 unlocks. The values 2'b00 and 2'b11 change nothing, but they still consume the arm.
- R6: While unlocked, a bus write to byte offset 0x310 + 4*n (n = 0..63) stores the write data in word n.
- R7: While locked, a bus write to a table word leaves that word unchanged.
- R8: `bus_rdata` holds, one cycle after `bus_addr` is presented, the value at that address, taken before any write in that same cycle. A table word reads its contents. The lock-control register reads {30'b0, unlocked, locked}. The key register, unmapped offsets and offsets with nonzero bits [1:0] read 0.
- R9: `seq_data` holds, one cycle after `seq_addr` is presented, the table word at index `seq_addr`, independent of bus activity in that cycle.
- R10: `locked` always shows the current lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe for this cycle |
| bus_addr | input | 11 | Bus byte address within the block |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| seq_addr | input | 6 | Sequencer word index |
| seq_data | output | 32 | Registered sequencer read data |
| locked | output | 1 | Current lock state |

## Verification
A wrong lock state shows on `locked` in the cycle after the write that caused it. It also shows one cycle later in a lock-register read and in the first table write that is dropped or accepted when it should not be. A stale arm flag stays hidden until the next lock-control write, so the stimulus puts key, idle, intervening and lock writes in many orders. A corrupted table word shows on either read port one cycle after its index is presented. For that reason, both ports are compared every cycle against a behavioural model, both during directed sequences and during a long random phase.

// File: rtl/lutk_pkg.sv
package lutk_pkg;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_KEY   = 2'd1,
        TGT_LOCK  = 2'd2,
        TGT_TABLE = 2'd3
    } tgt_e;

    localparam logic [5:0] OP_STOP = 6'd0;
    localparam logic [5:0] OP_CMD  = 6'd1;
    localparam logic [5:0] OP_ADDR = 6'd2;
    localparam logic [5:0] OP_READ = 6'd7;

    // one 16-bit instruction slot: opcode, lane code, operand
    function automatic logic [15:0] mk_slot(logic [5:0] op, logic [1:0] lanes, logic [7:0] opr);
        return {op, lanes, opr};
    endfunction

    // reset image: sequence 0 is a basic single-lane read
    function automatic logic [31:0] preset_word(int idx);
        logic [31:0] w;
        case (idx)
            0:       w = {mk_slot(OP_ADDR, 2'd0, 8'd24), mk_slot(OP_CMD, 2'd0, 8'h03)};
            1:       w = {mk_slot(OP_STOP, 2'd0, 8'd0),  mk_slot(OP_READ, 2'd0, 8'h04)};
            default: w = 32'h0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/lutk_decode.sv
module lutk_decode
    import lutk_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int KEY_OFS   = 'h300,
    parameter int LOCK_OFS  = 'h304,
    parameter int TABLE_OFS = 'h310,
    parameter int NUM_WORDS = 64
) (
    input  logic [ADDR_W-1:0]            addr,
    output tgt_e                         tgt,
    output logic [$clog2(NUM_WORDS)-1:0] idx
);
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int WA    = ADDR_W - 2;
    localparam logic [WA-1:0] KEY_WA  = WA'(KEY_OFS / 4);
    localparam logic [WA-1:0] LOCK_WA = WA'(LOCK_OFS / 4);
    localparam logic [WA-1:0] TBL_WA  = WA'(TABLE_OFS / 4);
    localparam logic [WA-1:0] NW_WA   = WA'(NUM_WORDS);

    logic [WA-1:0] wa;
    logic [WA-1:0] off;

    assign wa  = addr[ADDR_W-1:2];
    assign off = wa - TBL_WA;
    assign idx = off[IDX_W-1:0];

    always_comb begin
        tgt = TGT_NONE;
        if (addr[1:0] == 2'b00) begin
            if (wa == KEY_WA)
                tgt = TGT_KEY;
            else if (wa == LOCK_WA)
                tgt = TGT_LOCK;
            else if ((wa >= TBL_WA) && (off < NW_WA))
                tgt = TGT_TABLE;
        end
    end
endmodule

// File: rtl/lutk_guard.sv
module lutk_guard
    import lutk_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY = 32'h5AF0_5AF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    typedef struct packed {
        logic locked;
        logic armed;
    } guard_t;

    guard_t st_d, st_q;
    logic   key_ok;

    assign key_ok = wr_en && (tgt == TGT_KEY) && (wdata == KEY);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.armed = key_ok;
            if ((tgt == TGT_LOCK) && st_q.armed) begin
                case (wdata[1:0])
                    2'b01:   st_d.locked = 1'b1;
                    2'b10:   st_d.locked = 1'b0;
                    default: st_d.locked = st_q.locked;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.locked <= 1'b1;
            st_q.armed  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

    // R3
    lock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> $stable(st_q.locked));

    // R3
    arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(key_ok));

    // R4
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_ok) |=> !st_q.armed);

    // R5
    both_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (tgt == TGT_LOCK) && (wdata[1:0] == 2'b11)) |=> $stable(st_q.locked));
endmodule

// File: rtl/lutk_store.sv
module lutk_store
    import lutk_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int DATA_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(NUM_WORDS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [$clog2(NUM_WORDS)-1:0] rd_a_idx,
    output logic [DATA_W-1:0]            rd_a_data,
    input  logic [$clog2(NUM_WORDS)-1:0] rd_b_idx,
    output logic [DATA_W-1:0]            rd_b_data
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] words;
        logic [DATA_W-1:0]                rd_a;
        logic [DATA_W-1:0]                rd_b;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rd_a = st_q.words[rd_a_idx];
        st_d.rd_b = st_q.words[rd_b_idx];
        if (wr_en)
            st_d.words[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++)
                st_q.words[i] <= DATA_W'(preset_word(i));
            st_q.rd_a <= '0;
            st_q.rd_b <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_data = st_q.rd_a;
    assign rd_b_data = st_q.rd_b;

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.words[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/lutk_table.sv
module lutk_table
    import lutk_pkg::*;
#(
    parameter int                ADDR_W    = 11,
    parameter int                DATA_W    = 32,
    parameter int                NUM_WORDS = 64,
    parameter int                KEY_OFS   = 'h300,
    parameter int                LOCK_OFS  = 'h304,
    parameter int                TABLE_OFS = 'h310,
    parameter logic [DATA_W-1:0] KEY       = 32'h5AF0_5AF0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr_en,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [$clog2(NUM_WORDS)-1:0] seq_addr,
    output logic [DATA_W-1:0]            seq_data,
    output logic                         locked
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    typedef struct packed {
        tgt_e sel;
        logic lk;
    } rdsel_t;

    tgt_e              tgt;
    logic [IDX_W-1:0]  idx;
    logic              lock_st;
    logic              tbl_we;
    logic [DATA_W-1:0] tbl_rd;
    rdsel_t            rd_d, rd_q;

    lutk_decode #(
        .ADDR_W(ADDR_W), .KEY_OFS(KEY_OFS), .LOCK_OFS(LOCK_OFS),
        .TABLE_OFS(TABLE_OFS), .NUM_WORDS(NUM_WORDS)
    ) i_decode (
        .addr(bus_addr), .tgt(tgt), .idx(idx)
    );

    lutk_guard #(.DATA_W(DATA_W), .KEY(KEY)) i_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .tgt(tgt),
        .wdata(bus_wdata), .locked(lock_st)
    );

    assign tbl_we = bus_wr_en && (tgt == TGT_TABLE) && !lock_st;

    lutk_store #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_idx(idx), .wr_data(bus_wdata),
        .rd_a_idx(idx), .rd_a_data(tbl_rd),
        .rd_b_idx(seq_addr), .rd_b_data(seq_data)
    );

    always_comb begin
        rd_d     = rd_q;
        rd_d.sel = tgt;
        rd_d.lk  = lock_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q.sel <= TGT_NONE;
            rd_q.lk  <= 1'b1;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        case (rd_q.sel)
            TGT_TABLE: bus_rdata = tbl_rd;
            TGT_LOCK:  bus_rdata = {{(DATA_W-2){1'b0}}, ~rd_q.lk, rd_q.lk};
            default:   bus_rdata = '0;
        endcase
    end

    assign locked = lock_st;
endmodule

// File: tb/test_lutk_table.sv
module test_lutk_table;
    localparam int KEYA = 'h300;
    localparam int LCKA = 'h304;
    localparam int TBLA = 'h310;
    localparam logic [31:0] KEYV = 32'h5AF0_5AF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  seq_addr = '0;
    logic [31:0] seq_data;
    logic        locked;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] ref_mem [64];
    bit          ref_locked;
    bit          ref_armed;
    logic [31:0] exp_rd;
    logic [31:0] exp_seq;

    always #5 clk = ~clk;

    lutk_table i_lutk_table (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_addr(seq_addr),
        .seq_data(seq_data), .locked(locked)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int a);
        if (a == LCKA) return {30'b0, !ref_locked, ref_locked};
        if (a >= TBLA && a < TBLA + 256 && (a % 4) == 0) return ref_mem[(a - TBLA) / 4];
        return 32'h0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 64; i++) ref_mem[i] = 32'h0;
        ref_mem[0] = 32'h0818_0403;
        ref_mem[1] = 32'h0000_1C04;
        ref_locked = 1'b1;
        ref_armed  = 1'b0;
    endtask

    // one bus cycle, then compare every output at the following negedge
    task automatic cyc(input bit wr, input int a, input logic [31:0] wd, input int sa, input string tag);
        bus_wr_en = wr;
        bus_addr  = a[10:0];
        bus_wdata = wd;
        seq_addr  = sa[5:0];
        @(posedge clk);
        exp_rd  = model_read(a);
        exp_seq = ref_mem[sa];
        if (wr) begin
            if (a == KEYA) begin
                ref_armed = (wd == KEYV);
            end else begin
                if (a == LCKA && ref_armed) begin
                    if (wd[1:0] == 2'b01) ref_locked = 1'b1;
                    else if (wd[1:0] == 2'b10) ref_locked = 1'b0;
                end
                if (a >= TBLA && a < TBLA + 256 && (a % 4) == 0 && !ref_locked)
                    ref_mem[(a - TBLA) / 4] = wd;
                ref_armed = 1'b0;
            end
        end
        @(negedge clk);
        bus_wr_en = 1'b0;
        chk({tag, "/R8"}, "bus_rdata", bus_rdata, exp_rd);
        chk({tag, "/R9"}, "seq_data", seq_data, exp_seq);
        chk({tag, "/R10"}, "locked", {31'b0, locked}, {31'b0, ref_locked});
    endtask

    task automatic rd(input int a, input int sa, input string tag);
        cyc(1'b0, a, 32'h0, sa, tag);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1", "locked in reset", {31'b0, locked}, 32'h1);
        rst_n = 1'b1;

        // R1: lock register readback after reset
        rd(LCKA, 0, "R1");
        chk("R1", "lock reg", bus_rdata, 32'h1);
        // R2: preset image on both ports
        rd(TBLA, 0, "R2");
        chk("R2", "word0", bus_rdata, 32'h0818_0403);
        rd(TBLA + 4, 1, "R2");
        chk("R2", "word1", bus_rdata, 32'h0000_1C04);
        rd(TBLA + 8, 2, "R2");
        rd(TBLA + 12, 3, "R2");
        rd(TBLA + 4 * 63, 63, "R2");
        chk("R2", "word63", bus_rdata, 32'h0);
        rd(KEYA, 5, "R8");
        rd('h301, 0, "R8");

        // R7: write while locked is dropped
        wr(TBLA, 32'hDEAD_BEEF, "R7");
        rd(TBLA, 0, "R7");
        chk("R7", "word0 kept", bus_rdata, 32'h0818_0403);

        // R3/R5: key then unlock
        wr(KEYA, KEYV, "R3");
        wr(LCKA, 32'h2, "R5");
        chk("R5", "unlocked", {31'b0, locked}, 32'h0);
        rd(LCKA, 0, "R8");
        chk("R8", "lock reg unlocked", bus_rdata, 32'h2);

        // R6: table writes while unlocked, read back with same-cycle semantics
        wr(TBLA + 4 * 5, 32'h1234_5678, "R6");
        wr(TBLA + 4 * 63, 32'hA5A5_0F0F, "R6");
        cyc(1'b1, TBLA, 32'h0BAD_F00D, 0, "R8");
        rd(TBLA, 63, "R6");
        chk("R6", "word0 new", bus_rdata, 32'h0BAD_F00D);
        chk("R9", "seq word63", seq_data, 32'hA5A5_0F0F);

        // R3: idle cycles keep the arm
        wr(KEYA, KEYV, "R3");
        rd(TBLA, 0, "R3");
        rd(LCKA, 0, "R3");
        wr(LCKA, 32'h1, "R3");
        chk("R3", "locked after idle", {31'b0, locked}, 32'h1);

        // R4: intervening writes disarm
        wr(KEYA, KEYV, "R4");
        wr(TBLA + 8, 32'h1, "R4");
        wr(LCKA, 32'h2, "R4");
        chk("R4", "still locked", {31'b0, locked}, 32'h1);
        wr(KEYA, 32'h5AF0_5AF1, "R4");
        wr(LCKA, 32'h2, "R4");
        chk("R4", "wrong key", {31'b0, locked}, 32'h1);
        wr(LCKA, 32'h2, "R3");
        chk("R3", "no key", {31'b0, locked}, 32'h1);

        // R5: both bits ignored and arm consumed
        wr(KEYA, KEYV, "R5");
        wr(LCKA, 32'h3, "R5");
        wr(LCKA, 32'h2, "R5");
        chk("R5", "both bits", {31'b0, locked}, 32'h1);
        wr(KEYA, KEYV, "R5");
        wr(LCKA, 32'h0, "R5");
        chk("R5", "zero bits", {31'b0, locked}, 32'h1);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 8;
            case (r)
                0, 1: wr(KEYA, ($urandom % 4 == 0) ? $urandom : KEYV, "R3");
                2, 3: wr(LCKA, $urandom, "R5");
                4, 5: wr(TBLA + 4 * ($urandom % 64), $urandom, "R6");
                6:    rd(TBLA + 4 * ($urandom % 64), $urandom % 64, "R9");
                default: rd(($urandom % 2) ? LCKA : 'h500, $urandom % 64, "R8");
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule